// File: doc/BRIEF.md
# Interval-Based Self-Test Sequencer

This block runs a processor built-in self-test as a chain of fixed-length intervals. There are 24 intervals, numbered 0 to 23, and each lasts 1365 test cycles. A single triggered run executes only part of the test: software chooses how many intervals the run covers. Software also chooses whether the run resumes at the interval after the last one executed or starts again at interval 0. Full coverage is reached only when all 24 intervals have been executed. While a run is active the processor is held unavailable through `cpu_hold`.

Software uses a small register interface. It writes the configuration word, then writes the start bit. It can poll the status word or wait for the one-cycle `run_done` pulse, and it reads the executed-interval count and the saved position. During each interval the block drives a pattern word toward a stubbed core-under-test port. The pattern generator is reseeded from the index of the interval being applied. A compare strobe is raised on the last cycle of every interval.

The sequencer has four states. `ST_IDLE` goes to `ST_PREP` on an accepted start. `ST_PREP` applies the restart or wrap clearing and loads the interval budget. From there it goes to `ST_RUN`, or to `ST_FINISH` when the budget is zero. `ST_RUN` stays in place while intervals remain. It goes to `ST_FINISH` at the end of the last budgeted interval or at the end of interval 23. `ST_FINISH` always returns to `ST_IDLE`.

Register map (`reg_addr`):
- 0 CONFIG: bits [4:0] interval budget, bit 8 restart.
- 1 COMMAND: a write with bit 0 set requests a start. This address reads as zero.
- 2 STATUS: bit 0 busy, bit 1 sticky done, bit 2 full test complete.
- 3 PROGRESS: bits [4:0] executed-interval count, bits [12:8] saved position.

Top module: `stc_interval_sequencer`

## Requirements
- R1: After reset the block is idle and `cpu_hold`, `run_done` and `cut_compare` are low. The CONFIG, STATUS and PROGRESS registers all read zero.
- R2: A COMMAND write with bit 0 set starts a run only from idle. `cpu_hold` then stays high for exactly N*1365+2 cycles, where N is the number of intervals executed.
- R3: Every interval lasts 1365 cycles. `cut_compare` pulses once, on the last cycle of each interval, so a run produces exactly N strobes.
- R4: The executed-interval count in PROGRESS[4:0] rises by one at the end of each interval. Otherwise it only changes by being cleared to zero.
- R5: When CONFIG bit 8 is 0, a run resumes at the saved position. Two consecutive runs with a budget of 8, starting from reset, leave the count at 16 and the position at 16.
- R6: When CONFIG bit 8 is 1, the position and the count are both cleared before the first interval, so the first interval executed is interval 0.
- R7: A run whose budget exceeds the intervals remaining stops after interval 23. It then sets STATUS bit 2, and the position reads 24. The next run starts at interval 0, with the count cleared and STATUS bit 2 cleared.
- R8: While a run is active, CONFIG writes are ignored and further start writes have no effect.
- R9: At the end of a run, `run_done` is high for exactly one cycle and STATUS bit 1 becomes set. STATUS bit 1 stays set until the next accepted start clears it. The position is kept for later resumption.
- R10: A start with a budget of 0 executes no interval. It still holds the processor for 2 cycles and signals done.
- R11: `cut_index` shows the interval being applied. The pattern generator is reseeded for each interval and never holds the all-zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on address) |
| cpu_hold | output | 1 | Processor held unavailable while a run is active |
| run_done | output | 1 | One-cycle pulse at the end of a run |
| cut_pattern | output | 16 | Stimulus word to the core under test |
| cut_compare | output | 1 | Response compare strobe, last cycle of each interval |
| cut_index | output | 5 | Interval currently applied (saved position when idle) |

## Verification
The assertions assume that `reg_addr`, `reg_we` and `reg_wdata` are driven to known values in every cycle. They also assume that reset is applied before the first start. The frozen-configuration property further assumes that a write never coincides with the clock edge on which reset is released. The bench drives all register inputs from the falling edge and holds `reg_we` low except during its single-cycle write tasks. It asserts reset for several cycles before any access, so every bus transaction is clean and one cycle wide.

// File: rtl/stc_seq_pkg.sv
package stc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREP,
        ST_RUN,
        ST_FINISH
    } seq_state_t;

    localparam logic [1:0] ADDR_CONFIG   = 2'd0;
    localparam logic [1:0] ADDR_COMMAND  = 2'd1;
    localparam logic [1:0] ADDR_STATUS   = 2'd2;
    localparam logic [1:0] ADDR_PROGRESS = 2'd3;

    localparam int RESTART_BIT  = 8;
    localparam int POSITION_LSB = 8;

endpackage

// File: rtl/stc_regs.sv
module stc_regs
    import stc_seq_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    input  logic             busy,
    input  logic             finish_pulse,
    input  logic             complete,
    input  logic [IDX_W-1:0] count,
    input  logic [IDX_W-1:0] position,
    output logic [IDX_W-1:0] cfg_len,
    output logic             cfg_restart,
    output logic             start_req,
    output logic [31:0]      reg_rdata
);

    logic [IDX_W-1:0] len_q;
    logic             restart_q;
    logic             done_sticky_q;

    assign start_req   = reg_we && (reg_addr == ADDR_COMMAND) && reg_wdata[0] && !busy;
    assign cfg_len     = len_q;
    assign cfg_restart = restart_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q     <= '0;
            restart_q <= 1'b0;
        end else if (reg_we && (reg_addr == ADDR_CONFIG) && !busy) begin
            len_q     <= reg_wdata[IDX_W-1:0];
            restart_q <= reg_wdata[RESTART_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_sticky_q <= 1'b0;
        end else if (start_req) begin
            done_sticky_q <= 1'b0;
        end else if (finish_pulse) begin
            done_sticky_q <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CONFIG: begin
                reg_rdata[IDX_W-1:0]   = len_q;
                reg_rdata[RESTART_BIT] = restart_q;
            end
            ADDR_COMMAND: reg_rdata = '0;
            ADDR_STATUS: begin
                reg_rdata[0] = busy;
                reg_rdata[1] = done_sticky_q;
                reg_rdata[2] = complete;
            end
            ADDR_PROGRESS: begin
                reg_rdata[IDX_W-1:0]                  = count;
                reg_rdata[POSITION_LSB +: IDX_W]      = position;
            end
            default: reg_rdata = '0;
        endcase
    end

    // Configuration must not move once a run has started
    assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(len_q) && $stable(restart_q)));

endmodule

// File: rtl/stc_cycle_timer.sv
module stc_cycle_timer #(
    parameter int CYCLES = 1365,
    parameter int CYC_W  = $clog2(CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic last
);

    localparam logic [CYC_W-1:0] LAST_CNT = CYC_W'(CYCLES - 1);

    logic [CYC_W-1:0] cnt_q;

    assign last = enable && (cnt_q == LAST_CNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable || last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_cycle_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT);

endmodule

// File: rtl/stc_pattern_gen.sv
module stc_pattern_gen #(
    parameter int PAT_W = 16,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] seed_idx,
    output logic [PAT_W-1:0] pattern
);

    logic [PAT_W-1:0] lfsr_q;
    logic [PAT_W-1:0] seed;
    logic             feedback;

    always_comb begin
        seed    = PAT_W'(32'h9E3779B9 * (32'(seed_idx) + 32'd1));
        seed[0] = 1'b1;
    end

    assign feedback = lfsr_q[PAT_W-1] ^ lfsr_q[PAT_W-3] ^ lfsr_q[PAT_W-4] ^ lfsr_q[PAT_W-6];
    assign pattern  = lfsr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= PAT_W'(1);
        end else if (load) begin
            lfsr_q <= seed;
        end else begin
            lfsr_q <= {lfsr_q[PAT_W-2:0], feedback};
        end
    end

    assert_lfsr_nonzero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

endmodule

// File: rtl/stc_interval_sequencer.sv
module stc_interval_sequencer
    import stc_seq_pkg::*;
#(
    parameter int NUM_INTERVALS = 24,
    parameter int CYCLES        = 1365,
    parameter int PAT_W         = 16,
    parameter int IDX_W         = $clog2(NUM_INTERVALS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             cpu_hold,
    output logic             run_done,
    output logic [PAT_W-1:0] cut_pattern,
    output logic             cut_compare,
    output logic [IDX_W-1:0] cut_index
);

    localparam logic [IDX_W-1:0] FINAL_IDX = IDX_W'(NUM_INTERVALS - 1);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] pos_q, count_q, rem_q;
    logic             complete_q;
    logic [IDX_W-1:0] cfg_len;
    logic             cfg_restart;
    logic             start_req;
    logic             busy;
    logic             interval_end;
    logic             last_interval;
    logic             wrap;
    logic             pat_load;
    logic [IDX_W-1:0] seed_idx;

    assign busy          = (state_q != ST_IDLE);
    assign wrap          = cfg_restart || complete_q;
    assign last_interval = (rem_q == IDX_W'(1)) || (pos_q == FINAL_IDX);

    stc_regs #(.IDX_W(IDX_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .busy         (busy),
        .finish_pulse (run_done),
        .complete     (complete_q),
        .count        (count_q),
        .position     (pos_q),
        .cfg_len      (cfg_len),
        .cfg_restart  (cfg_restart),
        .start_req    (start_req),
        .reg_rdata    (reg_rdata)
    );

    stc_cycle_timer #(.CYCLES(CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (state_q == ST_RUN),
        .last   (interval_end)
    );

    stc_pattern_gen #(.PAT_W(PAT_W), .IDX_W(IDX_W)) u_pattern (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pat_load),
        .seed_idx (seed_idx),
        .pattern  (cut_pattern)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_req) state_d = ST_PREP;
            ST_PREP:   state_d = (cfg_len == '0) ? ST_FINISH : ST_RUN;
            ST_RUN:    if (interval_end && last_interval) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cpu_hold    = 1'b0;
        run_done    = 1'b0;
        cut_compare = 1'b0;
        pat_load    = 1'b1;
        seed_idx    = pos_q;
        unique case (state_q)
            ST_IDLE: cpu_hold = 1'b0;
            ST_PREP: begin
                cpu_hold = 1'b1;
                seed_idx = wrap ? '0 : pos_q;
            end
            ST_RUN: begin
                cpu_hold    = 1'b1;
                cut_compare = interval_end;
                pat_load    = interval_end;
                seed_idx    = pos_q + 1'b1;
            end
            ST_FINISH: begin
                cpu_hold = 1'b1;
                run_done = 1'b1;
            end
            default: cpu_hold = 1'b0;
        endcase
    end

    assign cut_index = pos_q;

    // Interval position, executed count, remaining budget
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q      <= '0;
            count_q    <= '0;
            rem_q      <= '0;
            complete_q <= 1'b0;
        end else if (state_q == ST_PREP) begin
            rem_q      <= cfg_len;
            complete_q <= 1'b0;
            if (wrap) begin
                pos_q   <= '0;
                count_q <= '0;
            end
        end else if (state_q == ST_RUN && interval_end) begin
            pos_q   <= pos_q + 1'b1;
            count_q <= count_q + 1'b1;
            rem_q   <= rem_q - 1'b1;
            if (pos_q == FINAL_IDX) complete_q <= 1'b1;
        end
    end

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q != $past(count_q)) |-> ((count_q == $past(count_q) + IDX_W'(1)) || (count_q == '0)));

    assert_pos_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= IDX_W'(NUM_INTERVALS));

    assert_compare_in_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cut_compare |-> cpu_hold);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |=> (!run_done && !cpu_hold));

    assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_hold && !$past(cpu_hold)) |-> ($past(reg_we) && $past(reg_addr) == ADDR_COMMAND));

endmodule

// File: tb/tb_stc_interval_sequencer.sv
module tb_stc_interval_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int CYC        = 1365;
    localparam int NVEC       = 6;

    // Per run: budget, restart, expected strobes, count, position, complete, first index
    localparam int V_LEN[NVEC]   = '{8, 8, 10, 2, 3, 0};
    localparam int V_RST[NVEC]   = '{0, 0, 0, 0, 1, 0};
    localparam int V_STR[NVEC]   = '{8, 8, 8, 2, 3, 0};
    localparam int V_CNT[NVEC]   = '{8, 16, 24, 2, 3, 3};
    localparam int V_POS[NVEC]   = '{8, 16, 24, 2, 3, 3};
    localparam int V_CMP[NVEC]   = '{0, 0, 1, 0, 0, 0};
    localparam int V_FIRST[NVEC] = '{0, 8, 16, 0, 0, 0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cpu_hold, run_done, cut_compare;
    logic [15:0] cut_pattern;
    logic [4:0]  cut_index;

    int checks = 0;
    int fails  = 0;
    int hold_n, strobe_n, done_n, first_idx;
    logic [31:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    stc_interval_sequencer dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_hold(cpu_hold),
        .run_done(run_done), .cut_pattern(cut_pattern), .cut_compare(cut_compare),
        .cut_index(cut_index)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rdreg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Starts a run and observes it until cpu_hold falls
    task automatic run_and_watch(input int len, input int rs);
        wr(2'd0, (32'(rs) << 8) | 32'(len));
        wr(2'd1, 32'd1);
        hold_n = 0; strobe_n = 0; done_n = 0; first_idx = -1;
        for (int i = 0; i < 40000; i++) begin
            if (cut_compare && strobe_n == 0) first_idx = int'(cut_index);
            if (cpu_hold) hold_n++;
            if (cut_compare) strobe_n++;
            if (run_done) done_n++;
            if (!cpu_hold) break;
            @(negedge clk);
        end
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(!cpu_hold && !run_done && !cut_compare, "R1 outputs", int'(cpu_hold), 0);
        rdreg(2'd0, rd); chk(rd == 0, "R1 config", int'(rd), 0);
        rdreg(2'd2, rd); chk(rd == 0, "R1 status", int'(rd), 0);
        rdreg(2'd3, rd); chk(rd == 0, "R1 progress", int'(rd), 0);

        // Table-driven runs: R2 R3 R4 R5 R6 R7 R9 R10 R11
        for (int v = 0; v < NVEC; v++) begin
            run_and_watch(V_LEN[v], V_RST[v]);
            chk(hold_n == V_STR[v]*CYC + 2, "R2 hold length", hold_n, V_STR[v]*CYC + 2);
            chk(strobe_n == V_STR[v], "R3 strobes per run", strobe_n, V_STR[v]);
            chk(done_n == 1, "R9 done pulse", done_n, 1);
            rdreg(2'd3, rd);
            chk(int'(rd[4:0]) == V_CNT[v], "R4 R5 R6 count", int'(rd[4:0]), V_CNT[v]);
            chk(int'(rd[12:8]) == V_POS[v], "R5 R7 position", int'(rd[12:8]), V_POS[v]);
            rdreg(2'd2, rd);
            chk(int'(rd[2]) == V_CMP[v], "R7 complete flag", int'(rd[2]), V_CMP[v]);
            chk(rd[1] == 1'b1 && rd[0] == 1'b0, "R9 sticky done", int'(rd[1:0]), 2);
            if (V_STR[v] > 0)
                chk(first_idx == V_FIRST[v], "R11 first interval index", first_idx, V_FIRST[v]);
            else
                chk(first_idx == -1, "R10 no interval", first_idx, -1);
        end

        // R8 and R9: writes during a run, sticky clear on start
        wr(2'd0, 32'd1);
        wr(2'd1, 32'd1);
        rdreg(2'd2, rd);
        chk(rd[1:0] == 2'b01, "R9 sticky cleared at start", int'(rd[1:0]), 1);
        repeat (20) @(negedge clk);
        wr(2'd0, 32'h0000_0105);
        wr(2'd1, 32'd1);
        strobe_n = 0;
        for (int i = 0; i < 3000 && cpu_hold; i++) begin
            if (cut_compare) strobe_n++;
            @(negedge clk);
        end
        repeat (10) @(negedge clk);
        chk(!cpu_hold, "R8 start ignored while busy", int'(cpu_hold), 0);
        chk(strobe_n == 1, "R8 budget unchanged", strobe_n, 1);
        rdreg(2'd0, rd);
        chk(rd == 32'd1, "R8 config write ignored", int'(rd), 1);
        rdreg(2'd3, rd);
        chk(int'(rd[4:0]) == 4, "R8 count resumed", int'(rd[4:0]), 4);

        // R11: pattern never zero during idle sample
        chk(cut_pattern != 16'd0, "R11 pattern nonzero", int'(cut_pattern), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule